// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple word-wide register bus. Software programs a reload value and a control word. The 16-bit down-counter then decrements at a rate that comes from the source clock through two cascaded stages. The first stage is an 8-bit prescaler that divides by P+1. The second stage divides by 16, 32, 64 or 128. Software keeps the system alive by writing a fresh count into the counter register before the count runs out.

When the counter expires, it reloads from the reload register. Depending on two enable bits, the expiry latches a pending interrupt, starts a fixed-length system reset request pulse, or does both. A write of any value to the clear register drops the pending interrupt. A debug-acknowledge input can hold both outputs inactive while a mask bit in the control word is set. The underlying state keeps running while the outputs are masked.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads 0x0000_8039 (prescaler 0x80, division code 3, counting on, reset output on, interrupt off, debug mask off). The reload and counter registers read 0x8000, and both irq and rst_req are low.
- R2: Byte offsets are 0x00 control, 0x04 reload, 0x08 counter and 0x0C interrupt clear. Control bit 0 enables the reset output, bit 2 enables the interrupt, bit 5 enables counting, bits 4:3 select the division, bits 15:8 hold P and bit 16 is the debug mask. The reload register reads back what was written, the counter register reads the live count, and the clear register always reads zero.
- R3: While counting is enabled, one tick occurs every (P+1)*D source cycles. D is 16, 32, 64 or 128 for division codes 0, 1, 2 and 3.
- R4: Each tick decrements a nonzero count. A tick that finds the count at zero is an expiry, and it reloads the count from the reload register. A count of N therefore expires on the (N+1)th tick.
- R5: An expiry with the interrupt enabled sets a pending flag, and irq follows that flag. Any write to offset 0x0C clears the flag. With the interrupt disabled, an expiry leaves irq low.
- R6: An expiry with the reset output enabled drives rst_req high for exactly 128 source cycles, starting at the clock edge of the expiry. With the reset output disabled, rst_req stays low.
- R7: While control bit 16 is set and dbg_ack is high, irq and rst_req are both low. A pending interrupt shows on irq again once either condition goes away.
- R8: A write to the counter register loads the written low 16 bits. It also restarts the prescaler and divider, so the first tick follows a full (P+1)*D cycles later.
- R9: Clearing the counting enable freezes the count and the prescaler and divider phase. Setting the enable again resumes from the frozen phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_ack | input | 1 | Debug acknowledge from the processor |
| irq | output | 1 | Watchdog interrupt, level |
| rst_req | output | 1 | System reset request pulse |

## Verification
The assertions take for granted that every write strobe lasts one cycle with a word-aligned address. They also assume dbg_ack is a clean level in the clock domain. The bench drives all bus and debug inputs on the falling edge, and it issues each write as exactly one strobed cycle. Every timed scenario starts from a counter write, because that write restarts the prescaler and divider phase. The bench also sets a large reload value before any scenario where a second expiry would otherwise overlap the window being measured.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // word offsets (byte address bits 3:2)
  localparam logic [1:0] OFS_CTRL   = 2'd0;
  localparam logic [1:0] OFS_RELOAD = 2'd1;
  localparam logic [1:0] OFS_COUNT  = 2'd2;
  localparam logic [1:0] OFS_CLEAR  = 2'd3;

  // control word bit positions
  localparam int CB_RST_EN  = 0;
  localparam int CB_INT_EN  = 2;
  localparam int CB_DIV_LO  = 3;
  localparam int CB_RUN     = 5;
  localparam int CB_PRE_LO  = 8;
  localparam int CB_DBG_MSK = 16;

  typedef struct packed {
    logic       dbg_msk;
    logic [7:0] presc;
    logic       run;
    logic [1:0] div_sel;
    logic       int_en;
    logic       rst_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [CW-1:0] RST_RELOAD = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt_val,
  output wdog_ctrl_t    ctrl,
  output logic [CW-1:0] reload,
  output logic          cnt_wr,
  output logic          clr_wr,
  output logic [DW-1:0] rdata
);
  logic [1:0]  word;
  logic        ctrl_wr, reld_wr;
  wdog_ctrl_t  ctrl_d;
  logic [CW-1:0] reload_d;

  assign word    = addr[3:2];
  assign ctrl_wr = we && (word == OFS_CTRL);
  assign reld_wr = we && (word == OFS_RELOAD);
  assign cnt_wr  = we && (word == OFS_COUNT);
  assign clr_wr  = we && (word == OFS_CLEAR);

  always_comb begin
    ctrl_d   = ctrl;
    reload_d = reload;
    if (ctrl_wr) begin
      ctrl_d.rst_en  = wdata[CB_RST_EN];
      ctrl_d.int_en  = wdata[CB_INT_EN];
      ctrl_d.div_sel = wdata[CB_DIV_LO +: 2];
      ctrl_d.run     = wdata[CB_RUN];
      ctrl_d.presc   = wdata[CB_PRE_LO +: 8];
      ctrl_d.dbg_msk = wdata[CB_DBG_MSK];
    end
    if (reld_wr) reload_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.rst_en  <= 1'b1;
      ctrl.int_en  <= 1'b0;
      ctrl.div_sel <= 2'd3;
      ctrl.run     <= 1'b1;
      ctrl.presc   <= 8'h80;
      ctrl.dbg_msk <= 1'b0;
      reload       <= RST_RELOAD;
    end else begin
      ctrl   <= ctrl_d;
      reload <= reload_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (word)
      OFS_CTRL: begin
        rdata[CB_RST_EN]        = ctrl.rst_en;
        rdata[CB_INT_EN]        = ctrl.int_en;
        rdata[CB_DIV_LO +: 2]   = ctrl.div_sel;
        rdata[CB_RUN]           = ctrl.run;
        rdata[CB_PRE_LO +: 8]   = ctrl.presc;
        rdata[CB_DBG_MSK]       = ctrl.dbg_msk;
      end
      OFS_RELOAD: rdata[CW-1:0] = reload;
      OFS_COUNT:  rdata[CW-1:0] = cnt_val;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PW     = 8,
  parameter int DIV_LG = 4,
  parameter int NSEL   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    restart,
  input  logic [PW-1:0]           presc,
  input  logic [$clog2(NSEL)-1:0] div_sel,
  output logic                    tick
);
  localparam int DCW = DIV_LG + NSEL - 1;

  logic [PW-1:0]  pcnt, pcnt_d;
  logic [DCW-1:0] dcnt, dcnt_d;
  logic [DCW-1:0] lim_tab [NSEL];
  logic [DCW-1:0] dlim;
  logic           pre_hit;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = DCW'((1 << (DIV_LG + g)) - 1);
  end

  assign dlim    = lim_tab[div_sel];
  assign pre_hit = run && (pcnt >= presc);
  assign tick    = pre_hit && (dcnt >= dlim);

  always_comb begin
    pcnt_d = pcnt;
    dcnt_d = dcnt;
    if (restart) begin
      pcnt_d = '0;
      dcnt_d = '0;
    end else if (run) begin
      if (pre_hit) begin
        pcnt_d = '0;
        dcnt_d = tick ? '0 : dcnt + 1'b1;
      end else begin
        pcnt_d = pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      pcnt <= pcnt_d;
      dcnt <= dcnt_d;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CW    = 16,
  parameter int PULSE = 128,
  parameter logic [CW-1:0] RST_COUNT = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] reload,
  input  logic          int_en,
  input  logic          rst_en,
  input  logic          clr_wr,
  input  logic          out_mask,
  output logic [CW-1:0] cnt,
  output logic          expire,
  output logic          irq_pend,
  output logic          pulse_act,
  output logic          irq,
  output logic          rst_req
);
  localparam int PLW = (PULSE > 1) ? $clog2(PULSE) : 1;

  logic [CW-1:0]  cnt_d;
  logic           pend_d, act_d;
  logic [PLW-1:0] plen, plen_d;

  assign expire = tick && !cnt_wr && (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    if (cnt_wr)       cnt_d = cnt_wdata;
    else if (expire)  cnt_d = reload;
    else if (tick)    cnt_d = cnt - 1'b1;
  end

  always_comb begin
    pend_d = irq_pend;
    if (expire && int_en) pend_d = 1'b1;
    else if (clr_wr)      pend_d = 1'b0;
  end

  always_comb begin
    act_d  = pulse_act;
    plen_d = plen;
    if (expire && rst_en) begin
      act_d  = 1'b1;
      plen_d = PLW'(PULSE - 1);
    end else if (pulse_act) begin
      if (plen == '0) act_d = 1'b0;
      else            plen_d = plen - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= RST_COUNT;
      irq_pend  <= 1'b0;
      pulse_act <= 1'b0;
      plen      <= '0;
    end else begin
      cnt       <= cnt_d;
      irq_pend  <= pend_d;
      pulse_act <= act_d;
      plen      <= plen_d;
    end
  end

  assign irq     = irq_pend  && !out_mask;
  assign rst_req = pulse_act && !out_mask;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CW    = 16,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int PULSE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dbg_ack,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [CW-1:0] INIT_VAL = CW'(1 << (CW - 1));

  wdog_ctrl_t    ctrl;
  logic [CW-1:0] reload, cnt;
  logic          cnt_wr, clr_wr, tick, expire, irq_pend, pulse_act, out_mask;

  assign out_mask = ctrl.dbg_msk && dbg_ack;

  wdog_regs #(.CW(CW), .AW(AW), .DW(DW), .RST_RELOAD(INIT_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_val(cnt), .ctrl(ctrl), .reload(reload),
    .cnt_wr(cnt_wr), .clr_wr(clr_wr), .rdata(bus_rdata)
  );

  wdog_tick #(.PW(8), .DIV_LG(4), .NSEL(4)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(cnt_wr),
    .presc(ctrl.presc), .div_sel(ctrl.div_sel), .tick(tick)
  );

  wdog_core #(.CW(CW), .PULSE(PULSE), .RST_COUNT(INIT_VAL)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(bus_wdata[CW-1:0]), .reload(reload),
    .int_en(ctrl.int_en), .rst_en(ctrl.rst_en), .clr_wr(clr_wr),
    .out_mask(out_mask), .cnt(cnt), .expire(expire),
    .irq_pend(irq_pend), .pulse_act(pulse_act), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CW    = 16,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int PULSE = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          dbg_ack,
  input logic          irq,
  input logic          rst_req,
  input logic          dbg_msk,
  input logic          run,
  input logic          tick,
  input logic          expire,
  input logic          irq_pend,
  input logic          pulse_act,
  input logic [CW-1:0] cnt
);
  logic [$clog2(PULSE+2):0] act_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         act_len <= '0;
    else if (expire)    act_len <= 1;
    else if (pulse_act) act_len <= act_len + 1'b1;
    else                act_len <= '0;
  end

  AST_DBG_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_msk && dbg_ack) |-> (!irq && !rst_req)); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[3:2] == 2'd3 && !expire) |=> !irq_pend); // R5

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[3:2] == 2'd2) |=> (cnt == $past(bus_wdata[CW-1:0]))); // R8

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(bus_we && bus_addr[3:2] == 2'd2)) |=> $stable(cnt)); // R9

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R9

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_act) |-> (act_len == PULSE + 1)); // R6
endmodule

bind wdog_timer wdog_timer_chk #(.CW(CW), .AW(AW), .DW(DW), .PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .dbg_ack(dbg_ack), .irq(irq), .rst_req(rst_req),
  .dbg_msk(ctrl.dbg_msk), .run(ctrl.run), .tick(tick), .expire(expire),
  .irq_pend(irq_pend), .pulse_act(pulse_act), .cnt(cnt)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/100ps
module sim_wdog_timer;
  logic        clk, rst_n, bus_we, dbg_ack;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  wdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_ack(dbg_ack),
    .irq(irq), .rst_req(rst_req)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // write: returns 1ns after the capturing edge W
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  // combinational read at the current time
  task automatic peek(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); peek(a, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h0, v); chk("R1 ctrl", v, 32'h8039);
    rd(4'h4, v); chk("R1 reload", v, 32'h8000);
    rd(4'h8, v); chk("R1 count", v, 32'h8000);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(4'h0, 32'h0001_AB3D);
    rd(4'h0, v); chk("R2 ctrl readback", v, 32'h0001_AB3D);
    wr(4'h4, 32'hFFFF_1234);
    rd(4'h4, v); chk("R2 reload readback", v, 32'h1234);
    wr(4'h0, 32'h0);
    wr(4'h8, 32'h0000_0777);
    rd(4'h8, v); chk("R8 count load", v, 32'h777);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R2 clear reads zero", v, 0);
    rd(4'h8, v); chk("R2 clear write leaves count", v, 32'h777);
  endtask

  task automatic t_div16;
    logic [31:0] v;
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h24);
    wr(4'h8, 32'd3);
    repeat (63) @(posedge clk);
    @(negedge clk); chk("R4 no expiry before 4th tick", irq, 0);
    @(posedge clk);
    @(negedge clk); chk("R3 R5 irq at 64 cycles", irq, 1);
    peek(4'h8, v); chk("R4 reload after expiry", v, 32'd5);
    chk("R6 rst_req off when disabled", rst_req, 0);
    wr(4'hC, 32'h0);
    @(negedge clk); chk("R5 clear drops irq", irq, 0);
  endtask

  task automatic t_presc;
    wr(4'h4, 32'hFF);
    wr(4'h0, 32'h022C);
    wr(4'h8, 32'd0);
    repeat (95) @(posedge clk);
    @(negedge clk); chk("R3 P=2 div32 early", irq, 0);
    @(posedge clk);
    @(negedge clk); chk("R3 P=2 div32 at 96", irq, 1);
    wr(4'hC, 32'h1);
  endtask

  task automatic t_div128;
    wr(4'h0, 32'h3C);
    wr(4'h8, 32'd0);
    repeat (127) @(posedge clk);
    @(negedge clk); chk("R3 div128 early", irq, 0);
    @(posedge clk);
    @(negedge clk); chk("R3 div128 at 128", irq, 1);
    wr(4'hC, 32'h1);
  endtask

  task automatic t_rstpulse;
    wr(4'h0, 32'h21);
    wr(4'h8, 32'd0);
    repeat (15) @(posedge clk);
    @(negedge clk); chk("R6 rst_req before expiry", rst_req, 0);
    @(posedge clk);
    @(negedge clk); chk("R6 rst_req rises", rst_req, 1);
    repeat (127) @(posedge clk);
    @(negedge clk); chk("R6 rst_req last cycle", rst_req, 1);
    @(posedge clk);
    @(negedge clk); chk("R6 rst_req after 128", rst_req, 0);
    chk("R5 irq off when disabled", irq, 0);
  endtask

  task automatic t_debug;
    wr(4'h0, 32'h0001_0024);
    @(negedge clk); dbg_ack = 1;
    wr(4'h8, 32'd0);
    repeat (20) @(posedge clk);
    @(negedge clk); #1; chk("R7 irq masked", irq, 0);
    dbg_ack = 0; #1; chk("R7 irq shows when ack low", irq, 1);
    dbg_ack = 1; #1;
    wr(4'h0, 32'h24);
    @(negedge clk); chk("R7 irq shows when mask off", irq, 1);
    wr(4'hC, 32'h0);
    wr(4'h0, 32'h0001_0021);
    wr(4'h8, 32'd0);
    repeat (20) @(posedge clk);
    @(negedge clk); #1; chk("R7 rst_req masked", rst_req, 0);
    dbg_ack = 0; #1; chk("R7 rst_req shows", rst_req, 1);
    wr(4'h0, 32'h0);
    repeat (130) @(posedge clk);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    wr(4'h0, 32'h24);
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h04);
    repeat (200) @(posedge clk);
    rd(4'h8, v); chk("R9 count frozen", v, 32'd2);
    chk("R9 no irq while frozen", irq, 0);
    wr(4'h0, 32'h24);
    repeat (14) @(posedge clk);
    @(negedge clk); peek(4'h8, v); chk("R9 phase kept, before tick", v, 32'd2);
    @(posedge clk);
    @(negedge clk); peek(4'h8, v); chk("R9 phase kept, tick", v, 32'd1);
    wr(4'h0, 32'h0);
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; dbg_ack = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_regmap();
    t_div16();
    t_presc();
    t_div128();
    t_rstpulse();
    t_debug();
    t_freeze();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule